// File: doc/BRIEF.md
# Debug Pin Acknowledge Handshake Controller

This block drives the optional acknowledge handshake on a single-wire, open-drain debug pin. A run-time flag decides whether the handshake is active. Two dedicated debug commands set and clear the flag, and reset leaves it clear. While the flag is set, every finished command answers the host with a timed low pulse on the pin. A single cycle of active-high speedup drive follows the pulse, and then the pin is released.

An external command decoder supplies one-cycle strobes for the command classes: handshake on, handshake off, read, write and CPU-executed. The bus side reports when a data bus cycle completes, and the serial side reports when write data has been received. A read is answered once its bus cycle completes. A write is answered only when both its serial data and its bus cycle are in, in either order. The block drives two pin enables, one for pulling low and one for driving high. The pin's tri-state cell combines them. Host SYNC requests are not watched, and an acknowledge that collides with one is not arbitrated.

Top module: `dbg_ack_ctrl`

## Requirements
- R1: After reset both pin enables are low and the handshake is off. While it is off, read, write and CPU completions produce no pulse.
- R2: A handshake-on strobe sets the flag on the next edge. It is answered with its own acknowledge pulse, whose low drive starts in the cycle after the strobe.
- R3: A handshake-off strobe clears the flag on the next edge. Completions that come after that produce no pulse.
- R4: A read is outstanding from its strobe until bus completion. Its acknowledge fires in the cycle in which bus completion is reported, which may be the strobe cycle itself. Low drive starts in the next cycle.
- R5: A write fires only when both serial receipt and bus completion have been seen since its strobe, in either order or in the same cycle. Low drive starts in the cycle after the later of the two.
- R6: While the flag is set, a CPU-executed strobe fires an acknowledge, with low drive starting in the next cycle.
- R7: An acknowledge drives low for exactly 16 cycles and then drives high for exactly 1 cycle. After that both enables return low. The two enables are never high together.
- R8: A completion that arrives while an acknowledge is still being driven is dropped and never produces a later pulse.
- R9: A handshake-off strobe that arrives during an acknowledge does not shorten it. The pulse keeps its full low and high lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Debug clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_ack_on_i | input | 1 | Strobe: handshake-on command decoded |
| cmd_ack_off_i | input | 1 | Strobe: handshake-off command decoded |
| cmd_read_i | input | 1 | Strobe: read-type command started |
| cmd_write_i | input | 1 | Strobe: write-type command started |
| cmd_cpu_i | input | 1 | Strobe: CPU-executed command finished |
| bus_done_i | input | 1 | Data bus cycle has completed |
| ser_rx_done_i | input | 1 | Write data fully received on the pin |
| pin_drive_low_o | output | 1 | Enable for pulling the pin low |
| pin_drive_high_o | output | 1 | Enable for driving the pin high (speedup) |

## Verification
A fire decision is made in the cycle that completes a command. Because the phase state is registered, low drive appears exactly one cycle later, lasts 16 cycles, and is followed by one high cycle. Inputs are applied on falling edges and outputs are sampled on the next falling edge, so each sample shows the state after exactly one more rising edge. The bench therefore expects zeros in every cycle up to and including the firing cycle, and then the exact low/high/idle pattern cycle by cycle. The write sweep steps serial receipt and bus completion over every offset from 0 to 3 and computes the firing cycle as the larger of the two offsets.

// File: rtl/dbg_ack_pkg.sv
package dbg_ack_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } ack_phase_e;

  // Width of a down-counter that must hold values up to n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Total cycles an acknowledge occupies the pin.
  function automatic int unsigned ack_span(input int unsigned low_cyc,
                                           input int unsigned high_cyc);
    return low_cyc + high_cyc;
  endfunction

endpackage

// File: rtl/dbg_ack_enable.sv
module dbg_ack_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic off_i,
  output logic en_o
);

  logic en_q;

  // The on strobe wins if both strobes arrive in the same cycle.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)     en_q <= 1'b0;
    else if (on_i)   en_q <= 1'b1;
    else if (off_i)  en_q <= 1'b0;
  end

  assign en_o = en_q;

endmodule

// File: rtl/dbg_ack_trigger.sv
module dbg_ack_trigger (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic on_i,
  input  logic read_i,
  input  logic write_i,
  input  logic cpu_i,
  input  logic bus_done_i,
  input  logic rx_done_i,
  output logic rd_fire_o,
  output logic wr_fire_o,
  output logic fire_o
);

  logic rd_pend_q;
  logic wr_act_q, wr_rx_q, wr_bus_q;
  logic rd_arm, wr_arm, rx_seen, bus_seen;

  // Read: outstanding from its strobe until the bus reports completion.
  assign rd_arm    = rd_pend_q | read_i;
  assign rd_fire_o = rd_arm & bus_done_i;

  // Write: needs both the serial data and the bus completion, in any order.
  assign wr_arm    = wr_act_q | write_i;
  assign rx_seen   = wr_arm & (wr_rx_q  | rx_done_i);
  assign bus_seen  = wr_arm & (wr_bus_q | bus_done_i);
  assign wr_fire_o = rx_seen & bus_seen;

  // The on command answers itself; every other completion is gated by the flag.
  assign fire_o = on_i | (en_i & (rd_fire_o | wr_fire_o | cpu_i));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      wr_act_q  <= 1'b0;
      wr_rx_q   <= 1'b0;
      wr_bus_q  <= 1'b0;
    end else begin
      rd_pend_q <= rd_arm & ~bus_done_i;
      if (wr_fire_o) begin
        wr_act_q <= 1'b0;
        wr_rx_q  <= 1'b0;
        wr_bus_q <= 1'b0;
      end else begin
        wr_act_q <= wr_arm;
        wr_rx_q  <= rx_seen;
        wr_bus_q <= bus_seen;
      end
    end
  end

endmodule

// File: rtl/dbg_ack_pulse.sv
module dbg_ack_pulse
  import dbg_ack_pkg::*;
#(
  parameter int unsigned LOW_CYC  = 16,
  parameter int unsigned HIGH_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic busy_o,
  output logic drive_low_o,
  output logic drive_high_o
);

  localparam int unsigned MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int unsigned CW   = cnt_width(MAXC);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYC - 1);

  ack_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: if (fire_i) begin
        ph_d  = PH_LOW;
        cnt_d = LOW_LAST;
      end
      PH_LOW: if (cnt_zero) begin
        ph_d  = PH_HIGH;
        cnt_d = HIGH_LAST;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      PH_HIGH: if (cnt_zero) begin
        ph_d  = PH_IDLE;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o       = (ph_q != PH_IDLE);
  assign drive_low_o  = (ph_q == PH_LOW);
  assign drive_high_o = (ph_q == PH_HIGH);

endmodule

// File: rtl/dbg_ack_ctrl.sv
module dbg_ack_ctrl #(
  parameter int unsigned ACK_LOW_CYC  = 16,
  parameter int unsigned ACK_HIGH_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_ack_on_i,
  input  logic cmd_ack_off_i,
  input  logic cmd_read_i,
  input  logic cmd_write_i,
  input  logic cmd_cpu_i,
  input  logic bus_done_i,
  input  logic ser_rx_done_i,
  output logic pin_drive_low_o,
  output logic pin_drive_high_o
);

  logic ack_en_w;
  logic ack_fire_w;
  logic ack_busy_w;
  logic rd_fire_w;
  logic wr_fire_w;

  dbg_ack_enable u_enable (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .on_i   (cmd_ack_on_i),
    .off_i  (cmd_ack_off_i),
    .en_o   (ack_en_w)
  );

  dbg_ack_trigger u_trigger (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ack_en_w),
    .on_i       (cmd_ack_on_i),
    .read_i     (cmd_read_i),
    .write_i    (cmd_write_i),
    .cpu_i      (cmd_cpu_i),
    .bus_done_i (bus_done_i),
    .rx_done_i  (ser_rx_done_i),
    .rd_fire_o  (rd_fire_w),
    .wr_fire_o  (wr_fire_w),
    .fire_o     (ack_fire_w)
  );

  dbg_ack_pulse #(
    .LOW_CYC  (ACK_LOW_CYC),
    .HIGH_CYC (ACK_HIGH_CYC)
  ) u_pulse (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (ack_fire_w),
    .busy_o       (ack_busy_w),
    .drive_low_o  (pin_drive_low_o),
    .drive_high_o (pin_drive_high_o)
  );

endmodule

// File: rtl/dbg_ack_ctrl_chk.sv
module dbg_ack_ctrl_chk #(
  parameter int unsigned ACK_LOW_CYC  = 16,
  parameter int unsigned ACK_HIGH_CYC = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_ack_on_i,
  input logic cmd_ack_off_i,
  input logic drive_low,
  input logic drive_high,
  input logic ack_en,
  input logic ack_fire,
  input logic ack_busy
);

  logic [15:0] low_run;
  logic [15:0] high_run;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      low_run  <= drive_low  ? low_run + 16'd1  : 16'd0;
      high_run <= drive_high ? high_run + 16'd1 : 16'd0;
    end
  end

  p_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drive_low && drive_high));

  p_high_follows_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_high) |-> $past(drive_low));

  p_low_length_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_low) |-> (low_run == 16'(ACK_LOW_CYC)));

  p_high_length_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_high) |-> (high_run == 16'(ACK_HIGH_CYC)));

  p_fire_gated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire |-> (ack_en || cmd_ack_on_i));

  p_on_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ack_on_i |=> ack_en);

  p_off_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ack_off_i && !cmd_ack_on_i) |=> !ack_en);

  p_start_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && !ack_busy) |=> drive_low);

  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_low && !$past(drive_low)) |-> !$past(ack_busy));

  p_off_keeps_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_low && low_run < 16'(ACK_LOW_CYC)) |=> (drive_low || drive_high));

endmodule

bind dbg_ack_ctrl dbg_ack_ctrl_chk #(
  .ACK_LOW_CYC  (ACK_LOW_CYC),
  .ACK_HIGH_CYC (ACK_HIGH_CYC)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_ack_on_i  (cmd_ack_on_i),
  .cmd_ack_off_i (cmd_ack_off_i),
  .drive_low     (pin_drive_low_o),
  .drive_high    (pin_drive_high_o),
  .ack_en        (ack_en_w),
  .ack_fire      (ack_fire_w),
  .ack_busy      (ack_busy_w)
);

// File: tb/dbg_ack_ctrl_tb.sv
module dbg_ack_ctrl_tb;

  localparam int LOW  = 16;
  localparam int HIGH = 1;
  localparam int SPAN = LOW + HIGH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack_on = 1'b0, ack_off = 1'b0, rd = 1'b0, wr = 1'b0, cpu = 1'b0;
  logic bus = 1'b0, rx = 1'b0;
  logic drv_l, drv_h;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbg_ack_ctrl #(.ACK_LOW_CYC(LOW), .ACK_HIGH_CYC(HIGH)) u_dut (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .cmd_ack_on_i     (ack_on),
    .cmd_ack_off_i    (ack_off),
    .cmd_read_i       (rd),
    .cmd_write_i      (wr),
    .cmd_cpu_i        (cpu),
    .bus_done_i       (bus),
    .ser_rx_done_i    (rx),
    .pin_drive_low_o  (drv_l),
    .pin_drive_high_o (drv_h)
  );

  task automatic clr();
    ack_on = 0; ack_off = 0; rd = 0; wr = 0; cpu = 0; bus = 0; rx = 0;
  endtask

  task automatic chk(input logic el, input logic eh, input string tag);
    checks++;
    if (drv_l !== el || drv_h !== eh) begin
      errors++;
      $display("FAIL %s: low/high got %b%b expected %b%b", tag, drv_l, drv_h, el, eh);
    end
  endtask

  // Cycle i after the firing cycle: low for 1..LOW, high for LOW+1..SPAN.
  function automatic logic exp_low(input int i);
    return (i >= 1 && i <= LOW);
  endfunction
  function automatic logic exp_high(input int i);
    return (i > LOW && i <= SPAN);
  endfunction

  // Called at the falling edge of the firing cycle, with that cycle's inputs set.
  task automatic expect_pulse(input string tag);
    for (int i = 1; i <= SPAN + 1; i++) begin
      @(negedge clk); clr();
      chk(exp_low(i), exp_high(i), tag);
    end
  endtask

  task automatic expect_none(input int n, input string tag);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); clr();
      chk(1'b0, 1'b0, tag);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    chk(1'b0, 1'b0, "R1 reset");
    rst_n = 1'b1;
    expect_none(2, "R1 idle after reset");

    // R1: handshake off after reset, completions stay silent
    rd = 1; bus = 1;          expect_none(SPAN + 1, "R1 read while off");
    wr = 1; rx = 1; bus = 1;  expect_none(SPAN + 1, "R1 write while off");
    cpu = 1;                  expect_none(SPAN + 1, "R1 cpu while off");

    // R2: on command answers itself
    ack_on = 1;               expect_pulse("R2 on ack");

    // R4: read, bus completion three cycles later
    rd = 1;                   expect_none(3, "R4 no early ack");
    bus = 1;                  expect_pulse("R4 read ack");
    // R4: read and bus completion in the same cycle
    rd = 1; bus = 1;          expect_pulse("R4 same-cycle read");

    // R5: write sweep over every serial/bus offset 0..3
    for (int drx = 0; drx < 4; drx++) begin
      for (int dbs = 0; dbs < 4; dbs++) begin
        int f;
        f = (drx > dbs) ? drx : dbs;
        for (int k = 0; k <= f; k++) begin
          if (k > 0) @(negedge clk);
          clr();
          wr  = (k == 0);
          rx  = (k == drx);
          bus = (k == dbs);
          chk(1'b0, 1'b0, "R5 no early write ack");
        end
        expect_pulse("R5 write ack");
      end
    end

    // R6: CPU-executed completion
    cpu = 1;                  expect_pulse("R6 cpu ack");

    // R8: second completion while busy is dropped
    cpu = 1;
    for (int i = 1; i <= SPAN + 1; i++) begin
      @(negedge clk); clr();
      chk(exp_low(i), exp_high(i), "R8 pulse with extra strobe");
      if (i == 8) cpu = 1;
    end
    expect_none(SPAN + 2, "R8 dropped completion");

    // R9: off during a pulse keeps it whole; R3: later completions silent
    cpu = 1;
    for (int i = 1; i <= SPAN + 1; i++) begin
      @(negedge clk); clr();
      chk(exp_low(i), exp_high(i), "R9 pulse survives off");
      if (i == 5) ack_off = 1;
    end
    rd = 1; bus = 1;          expect_none(SPAN + 1, "R3 read after off");
    cpu = 1;                  expect_none(SPAN + 1, "R3 cpu after off");

    // R2: re-enable, then a CPU completion acks again
    ack_on = 1;               expect_pulse("R2 re-enable ack");
    cpu = 1;                  expect_pulse("R2 cpu after re-enable");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule